// File: doc/BRIEF.md
# Timestamped Transmit Packet Scheduler

This block sits between a buffer of transmit words and a DAC sample interface. The words arrive on a ready/valid stream and are grouped into fixed-size packets. Each packet is one header word followed by `DATA_WORDS` data words, and every data word carries two IQ samples. The header holds a timestamp and a flag that picks the release mode. An immediate packet plays out as soon as sample strobes arrive. A timed packet waits until a local sample-time counter reaches its timestamp.

Software turns the stream on with a level enable. A second input can make that enable wait for the next rising edge of an external pulse-per-second input. While the block waits, it reads no word, so anything queued upstream stays intact and packet framing is kept. Header detection depends only on a word counter, so sample contents can never be taken for a header. Disabling the stream always leaves the parser sitting on a header boundary. The block keeps two status counts: one for late packets that were dropped and one for strobes that found no sample.

Top module: `txsched`

## Requirements
- R1: After reset, `inReady`, `dacStrobe`, `dacI`, `dacQ`, `curTime`, `lateCount` and `underrunCount` are all zero.
- R2: The header word holds the timestamp in bits [47:0] and the immediate flag in bit 48. Each data word holds two samples: the earlier one in bits [31:0] and the later one in bits [63:32]. Within a sample, I is in bits [15:0] and Q is in bits [31:16]. An immediate packet sends its 16 samples in that order, one per `sampleTick`, each shown on `dacI`/`dacQ` with `dacStrobe` high in the cycle after the tick. After the 8th data word, the next word is read as a header.
- R3: While `dacStrobe` is low, `dacI` and `dacQ` keep the last sample sent.
- R4: A timed packet (flag 0) sends its first sample on the tick whose `curTime` value equals the header timestamp. One cycle later, `curTime` therefore reads timestamp+1 when ticks are continuous.
- R5: A timed packet is late if its timestamp is below `curTime` plus the tick of the header cycle. A late packet is consumed whole without output, `lateCount` rises by one, and the word after it is read as a header.
- R6: If `armPps` is high when `streamEn` rises, no word is accepted, no sample is sent and `curTime` stays frozen until a rising edge of `pps`. That edge clears `curTime` to 0 and starts parsing. Words queued upstream beforehand are then used in full.
- R7: An enable with `armPps` low clears `curTime` to 0 and starts parsing in the next cycle.
- R8: Once started, `curTime` advances by exactly one on every `sampleTick`.
- R9: `underrunCount` rises by one on each tick while a packet is being sent and no data word is valid. No other tick changes it.
- R10: After `streamEn` falls, the block finishes by discarding the rest of the current packet and then stops accepting words. A later enable starts again on a header.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| streamEn | input | 1 | Stream enable level |
| armPps | input | 1 | Makes the enable wait for a pps rising edge |
| pps | input | 1 | Pulse-per-second input, already synchronized |
| sampleTick | input | 1 | DAC sample cadence strobe |
| inData | input | 64 | Packet word |
| inValid | input | 1 | inData is valid |
| inReady | output | 1 | Word accepted when high together with inValid |
| dacI | output | 16 | I sample to DAC |
| dacQ | output | 16 | Q sample to DAC |
| dacStrobe | output | 1 | New sample on dacI/dacQ |
| curTime | output | 48 | Local sample-time counter |
| lateCount | output | 16 | Count of dropped late packets |
| underrunCount | output | 16 | Count of ticks with no sample while sending |

## Verification
The bench uses the default build: 8 data words per packet (16 samples), a 48-bit time counter and 16-bit status counters. With this short packet, a stall partway through a packet, a flush of the remainder on disable, and forty randomly gapped packets all fit into a few thousand cycles. The 48-bit timestamp gives room to put header timestamps far ahead of or behind the counter.

// File: rtl/txsched_pkg.sv
package txsched_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ARMED_PPS,
    ST_READ_HDR,
    ST_WAIT_TIME,
    ST_SEND
  } state_t;

  // strobes from control to datapath
  typedef struct packed {
    logic hdrTake;
    logic emit;
    logic emitHi;
    logic late;
    logic underrun;
    logic timeClr;
    logic timeRun;
  } ctl_t;
endpackage

// File: rtl/txsched_ctrl.sv
module txsched_ctrl
  import txsched_pkg::*;
#(
  parameter int DATA_WORDS = 8
) (
  input  logic   clk,
  input  logic   rstN,
  input  logic   streamEn,
  input  logic   armPps,
  input  logic   pps,
  input  logic   sampleTick,
  input  logic   inValid,
  input  logic   immFlag,
  input  logic   hdrLate,
  input  logic   atTime,
  output logic   inReady,
  output ctl_t   ctl,
  output state_t state
);
  localparam int CW = (DATA_WORDS > 1) ? $clog2(DATA_WORDS) : 1;
  localparam logic [CW-1:0] LAST = CW'(DATA_WORDS - 1);

  state_t  nState;
  logic    dropPkt, nDrop;
  logic    ppsQ, ppsRise;
  logic    halfSel;
  logic    wordTake;
  logic    live;
  logic [CW-1:0] wordCnt;

  assign ppsRise = pps && !ppsQ;

  always_comb begin
    nState   = state;
    nDrop    = dropPkt;
    ctl      = '0;
    inReady  = 1'b0;
    wordTake = 1'b0;
    live     = streamEn && ((state == ST_SEND && !dropPkt) ||
                            (state == ST_WAIT_TIME && atTime));
    ctl.timeRun = sampleTick &&
                  (state == ST_READ_HDR || state == ST_WAIT_TIME || state == ST_SEND);
    case (state)
      ST_IDLE: begin
        if (streamEn) begin
          if (armPps) nState = ST_ARMED_PPS;
          else begin
            ctl.timeClr = 1'b1;
            nState      = ST_READ_HDR;
          end
        end
      end
      ST_ARMED_PPS: begin
        if (!streamEn) nState = ST_IDLE;
        else if (ppsRise) begin
          ctl.timeClr = 1'b1;
          nState      = ST_READ_HDR;
        end
      end
      ST_READ_HDR: begin
        if (!streamEn) nState = ST_IDLE;
        else begin
          inReady = 1'b1;
          if (inValid) begin
            ctl.hdrTake = 1'b1;
            nState      = ST_SEND;
            nDrop       = 1'b0;
            if (!immFlag) begin
              if (hdrLate) begin
                ctl.late = 1'b1;
                nDrop    = 1'b1;
              end else nState = ST_WAIT_TIME;
            end
          end
        end
      end
      ST_WAIT_TIME: begin
        if (!streamEn) begin
          nState = ST_SEND;
          nDrop  = 1'b1;
        end else if (atTime) nState = ST_SEND;
      end
      ST_SEND: begin
        if (!streamEn) nDrop = 1'b1;
      end
      default: nState = ST_IDLE;
    endcase

    // discard path: swallow words with no output
    if (state == ST_SEND && dropPkt) begin
      inReady  = 1'b1;
      wordTake = inValid;
    end

    // play path: one sample per tick, word retired after its upper half
    if (live && sampleTick) begin
      if (inValid) begin
        ctl.emit   = 1'b1;
        ctl.emitHi = halfSel;
        inReady    = halfSel;
        wordTake   = halfSel;
      end else ctl.underrun = 1'b1;
    end

    if (wordTake && wordCnt == LAST) nState = ST_READ_HDR;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      dropPkt <= 1'b0;
      ppsQ    <= 1'b0;
      halfSel <= 1'b0;
      wordCnt <= '0;
    end else begin
      state   <= nState;
      dropPkt <= nDrop;
      ppsQ    <= pps;
      if (ctl.hdrTake) begin
        wordCnt <= '0;
        halfSel <= 1'b0;
      end else begin
        if (wordTake) wordCnt <= wordCnt + 1'b1;
        if (ctl.emit) halfSel <= ~halfSel;
      end
    end
  end
endmodule

// File: rtl/txsched_dp.sv
module txsched_dp
  import txsched_pkg::*;
#(
  parameter int TS_W  = 48,
  parameter int SMP_W = 16,
  parameter int CNT_W = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctl_t               ctl,
  input  logic               sampleTick,
  input  logic [4*SMP_W-1:0] inData,
  output logic               immFlag,
  output logic               hdrLate,
  output logic               atTime,
  output logic [SMP_W-1:0]   dacI,
  output logic [SMP_W-1:0]   dacQ,
  output logic               dacStrobe,
  output logic [TS_W-1:0]    curTime,
  output logic [CNT_W-1:0]   lateCount,
  output logic [CNT_W-1:0]   underrunCount
);
  localparam int PAIR_W = 2 * SMP_W;

  logic [TS_W-1:0]   tsReg;
  logic [TS_W-1:0]   hdrTs;
  logic [PAIR_W-1:0] pick;

  assign hdrTs   = inData[TS_W-1:0];
  assign immFlag = inData[TS_W];
  // compare against the value the counter holds after this cycle
  assign hdrLate = {1'b0, hdrTs} < ({1'b0, curTime} + (TS_W+1)'(sampleTick));
  assign atTime  = (curTime == tsReg);
  assign pick    = ctl.emitHi ? inData[2*PAIR_W-1:PAIR_W] : inData[PAIR_W-1:0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curTime       <= '0;
      tsReg         <= '0;
      dacI          <= '0;
      dacQ          <= '0;
      dacStrobe     <= 1'b0;
      lateCount     <= '0;
      underrunCount <= '0;
    end else begin
      if (ctl.timeClr)      curTime <= '0;
      else if (ctl.timeRun) curTime <= curTime + 1'b1;
      if (ctl.hdrTake) tsReg <= hdrTs;
      dacStrobe <= ctl.emit;
      if (ctl.emit) begin
        dacI <= pick[SMP_W-1:0];
        dacQ <= pick[PAIR_W-1:SMP_W];
      end
      if (ctl.late)     lateCount     <= lateCount + 1'b1;
      if (ctl.underrun) underrunCount <= underrunCount + 1'b1;
    end
  end
endmodule

// File: rtl/txsched.sv
module txsched
  import txsched_pkg::*;
#(
  parameter int TS_W       = 48,
  parameter int SMP_W      = 16,
  parameter int DATA_WORDS = 8,
  parameter int CNT_W      = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               streamEn,
  input  logic               armPps,
  input  logic               pps,
  input  logic               sampleTick,
  input  logic [4*SMP_W-1:0] inData,
  input  logic               inValid,
  output logic               inReady,
  output logic [SMP_W-1:0]   dacI,
  output logic [SMP_W-1:0]   dacQ,
  output logic               dacStrobe,
  output logic [TS_W-1:0]    curTime,
  output logic [CNT_W-1:0]   lateCount,
  output logic [CNT_W-1:0]   underrunCount
);
  ctl_t   ctl;
  state_t ctlState;
  logic   immFlag, hdrLate, atTime;

  txsched_ctrl #(.DATA_WORDS(DATA_WORDS)) u_ctrl (
    .clk(clk), .rstN(rstN), .streamEn(streamEn), .armPps(armPps), .pps(pps),
    .sampleTick(sampleTick), .inValid(inValid), .immFlag(immFlag),
    .hdrLate(hdrLate), .atTime(atTime), .inReady(inReady), .ctl(ctl),
    .state(ctlState)
  );

  txsched_dp #(.TS_W(TS_W), .SMP_W(SMP_W), .CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .sampleTick(sampleTick), .inData(inData),
    .immFlag(immFlag), .hdrLate(hdrLate), .atTime(atTime), .dacI(dacI),
    .dacQ(dacQ), .dacStrobe(dacStrobe), .curTime(curTime),
    .lateCount(lateCount), .underrunCount(underrunCount)
  );
endmodule

// File: rtl/txsched_chk.sv
module txsched_chk
  import txsched_pkg::*;
#(
  parameter int TS_W  = 48,
  parameter int SMP_W = 16,
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             sampleTick,
  input logic             dacStrobe,
  input logic [SMP_W-1:0] dacI,
  input logic [SMP_W-1:0] dacQ,
  input logic [TS_W-1:0]  curTime,
  input logic [CNT_W-1:0] lateCount,
  input logic [CNT_W-1:0] underrunCount,
  input state_t           state
);
  // R2
  strobe_tick_chk: assert property (@(posedge clk) disable iff (!rstN)
    dacStrobe |-> $past(sampleTick));

  // R3
  hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !dacStrobe |-> ($stable(dacI) && $stable(dacQ)));

  // R8
  time_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (curTime == $past(curTime)) || (curTime == $past(curTime) + TS_W'(1)) ||
    (curTime == '0));

  // R5
  late_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (lateCount == $past(lateCount)) || (lateCount == $past(lateCount) + CNT_W'(1)));

  // R9
  under_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (underrunCount == $past(underrunCount)) ||
    (underrunCount == $past(underrunCount) + CNT_W'(1)));

  // R6
  armed_freeze_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_ARMED_PPS) |=> (curTime == $past(curTime) || curTime == '0));

  // R10
  idle_entry_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && $past(state) != ST_IDLE) |->
      ($past(state) == ST_READ_HDR || $past(state) == ST_ARMED_PPS));
endmodule

bind txsched txsched_chk #(.TS_W(TS_W), .SMP_W(SMP_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rstN(rstN), .sampleTick(sampleTick), .dacStrobe(dacStrobe),
  .dacI(dacI), .dacQ(dacQ), .curTime(curTime), .lateCount(lateCount),
  .underrunCount(underrunCount), .state(ctlState)
);

// File: tb/txsched_bench.sv
module txsched_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 8;

  logic clk = 0, rstN = 0, streamEn = 0, armPps = 0, pps = 0, sampleTick = 0;
  logic inValid = 0;
  logic [63:0] inData = '0;
  logic inReady, dacStrobe;
  logic [15:0] dacI, dacQ, lateCount, underrunCount;
  logic [47:0] curTime;

  txsched u_txsched (
    .clk(clk), .rstN(rstN), .streamEn(streamEn), .armPps(armPps), .pps(pps),
    .sampleTick(sampleTick), .inData(inData), .inValid(inValid), .inReady(inReady),
    .dacI(dacI), .dacQ(dacQ), .dacStrobe(dacStrobe), .curTime(curTime),
    .lateCount(lateCount), .underrunCount(underrunCount)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  logic [63:0] wordQ[$];
  logic [31:0] expQ[$];
  longint      expT[$];
  int errors = 0, checks = 0;
  bit gapMode = 0, tickRand = 0, takeR = 0;

  task automatic chk(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  function automatic logic [31:0] smp(int p, int s);
    logic [15:0] iv;
    iv = {p[7:0], s[7:0]};
    return {~iv, iv};
  endfunction

  task automatic pushHead(bit imm, longint ts);
    logic [47:0] t;
    t = ts[47:0];
    wordQ.push_back({15'b0, imm, t});
  endtask

  task automatic pushData(int p, int w0, int w1);
    for (int w = w0; w <= w1; w++) wordQ.push_back({smp(p, 2*w+1), smp(p, 2*w)});
  endtask

  task automatic expectPkt(int p, bit imm, longint ts);
    for (int s = 0; s < 2*DW; s++) begin
      expQ.push_back(smp(p, s));
      expT.push_back((s == 0 && !imm) ? ts : -1);
    end
  endtask

  task automatic pushPkt(int p, bit imm, longint ts, bit keep);
    pushHead(imm, ts);
    pushData(p, 0, DW-1);
    if (keep) expectPkt(p, imm, ts);
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic drain(int limit);
    int k = 0;
    while ((expQ.size() > 0 || wordQ.size() > 0) && k < limit) begin
      cyc(1);
      k++;
    end
    cyc(4);
    chk(expQ.size() == 0, "R2 all expected samples sent", expQ.size(), 0);
  endtask

  // stream driver
  always @(posedge clk) takeR <= inValid && inReady;
  always @(negedge clk) begin
    if (takeR && wordQ.size() > 0) void'(wordQ.pop_front());
    inValid = (wordQ.size() > 0) && (!gapMode || $urandom_range(0, 3) != 0);
    inData  = inValid ? wordQ[0] : '0;
    sampleTick = !tickRand || ($urandom_range(0, 1) == 1);
  end

  // output monitor (R2 order/fields, R4 release time)
  always @(negedge clk) begin
    if (rstN && dacStrobe) begin
      if (expQ.size() == 0) chk(0, "R2 unexpected strobe", {dacQ, dacI}, 0);
      else begin
        logic [31:0] e;
        longint t;
        e = expQ.pop_front();
        t = expT.pop_front();
        chk({dacQ, dacI} == e, "R2 sample value", {dacQ, dacI}, e);
        if (t >= 0) chk(longint'(curTime) - 1 == t, "R4 release time",
                        longint'(curTime) - 1, t);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=0 expected=1");
    summary();
  end

  initial begin
    longint t1, tf;
    int lc, uc;
    void'($urandom(32'd4242));
    cyc(5);
    // R1
    chk(inReady == 0 && dacStrobe == 0, "R1 handshake/strobe", {inReady, dacStrobe}, 0);
    chk({dacI, dacQ} == 0, "R1 dac outputs", {dacI, dacQ}, 0);
    chk(curTime == 0 && lateCount == 0 && underrunCount == 0, "R1 counters",
        curTime, 0);
    rstN = 1;
    cyc(2);
    chk(curTime == 0 && inReady == 0, "R1 idle after release", curTime, 0);

    // R7 / R8 plain start
    streamEn = 1;
    cyc(2);
    chk(curTime == 1, "R7 counter cleared at start", curTime, 1);
    t1 = curTime;
    cyc(1);
    chk(curTime == t1 + 1, "R8 one step per tick", curTime, t1 + 1);
    pushPkt(1, 1, 48'hFFFF_0000_1234, 1);
    pushPkt(2, 1, 0, 1);
    drain(400);

    // R10 disable at a boundary: nothing accepted while off
    streamEn = 0;
    cyc(3);
    tf = curTime;
    pushPkt(3, 1, 48'h0001_0000_0000, 1);
    cyc(10);
    chk(wordQ.size() == DW + 1, "R10 no word taken while off", wordQ.size(), DW + 1);
    chk(curTime == tf, "R10 counter stopped while off", curTime, tf);

    // R6 armed start with buffered data
    armPps = 1;
    streamEn = 1;
    pushPkt(4, 0, 20, 1);
    cyc(30);
    chk(wordQ.size() == 2*(DW + 1), "R6 buffered words kept", wordQ.size(), 2*(DW + 1));
    chk(curTime == tf, "R6 counter frozen while armed", curTime, tf);
    chk(expQ.size() == 4*DW, "R6 no sample before pps", expQ.size(), 4*DW);
    pps = 1;
    cyc(2);
    chk(curTime == 1, "R6 counter cleared on pps edge", curTime, 1);
    pps = 0;
    armPps = 0;
    drain(400);

    // R4 timed release
    uc = underrunCount;
    t1 = curTime;
    pushPkt(10, 0, t1 + 100, 1);
    drain(600);

    // R5 late drop, next header still aligned
    lc = lateCount;
    pushPkt(11, 0, 5, 0);
    pushPkt(12, 1, 0, 1);
    drain(400);
    chk(lateCount == lc + 1, "R5 late count", lateCount, lc + 1);
    chk(underrunCount == uc, "R9 no count outside sending", underrunCount, uc);

    // R9 stall mid-packet
    pushHead(1, 0);
    pushData(13, 0, 1);
    expectPkt(13, 1, 0);
    cyc(30);
    chk(underrunCount - uc >= 10, "R9 underruns counted", underrunCount - uc, 10);
    pushData(13, 2, DW-1);
    drain(400);

    // R10 disable while holding a timed packet: rest flushed
    pushPkt(14, 0, longint'(curTime) + 5000, 0);
    cyc(20);
    streamEn = 0;
    cyc(20);
    chk(wordQ.size() == 0, "R10 remainder flushed", wordQ.size(), 0);
    streamEn = 1;
    cyc(2);
    chk(curTime == 1, "R7 restart clears counter", curTime, 1);
    pushPkt(15, 1, 48'h0000_DEAD_BEEF, 1);
    drain(400);

    // R2 random gaps and ticks
    gapMode = 1;
    tickRand = 1;
    for (int p = 20; p < 60; p++) pushPkt(p, 1, $urandom, 1);
    drain(20000);
    gapMode = 0;
    tickRand = 0;
    cyc(5);
    summary();
  end
endmodule